// File: doc/BRIEF.md
# Indirect 64-bit Register Bridge

This block sits on a 32-bit register bus and opens a bank of 64-bit configuration and status registers through a window of four 32-bit slots: a long-register address slot, a low-word slot, a high-word slot and a strobe slot. A write to the strobe commits the staged 64-bit value to the addressed long register. A read of the strobe copies the addressed long register into a 64-bit read latch. The high and low slots then return the two halves of that latch.

The long bank holds six host-written configuration registers: channel mask, divider count, trigger level, trigger kind, trigger enable and fill limit. It also holds a reserved slot, three live status registers (elapsed time, current input levels and capture flags), a capture-control register and a constant identification word. The capture-control register keeps an arm bit as a level. Its clear and flush bits leave as single-cycle pulses to the capture logic, which is outside this block. The live status registers are plain inputs here.

Bus accesses are single-cycle requests. A read answers with data and a valid flag exactly one clock later.

Top module: `lreg_bridge`

## Requirements
- R1: The window occupies four word addresses at WIN_BASE: +0x0 strobe, +0x4 long address, +0x8 low word, +0xC high word. The long-address slot reads back the last value written to it. Any other short address reads as zero, and writes to it change nothing.
- R2: A strobe write commits {high slot, low slot} to the long register named by the address slot. Configuration outputs show the new value from the cycle after the strobe write.
- R3: A strobe read copies the addressed long register into the read latch and itself returns zero. High and low slot reads return bits 63:32 and 31:0 of the latch. Until the first strobe read after reset the latch is zero, so a first high or low read can be stale.
- R4: Long register 100 reads as 0x1234567887654321, and writes to it are ignored.
- R5: Long registers 0 to 5 (channel mask, divider count, trigger level, trigger kind, trigger enable, fill limit) are read/write and drive the matching outputs.
- R6: Long registers 7, 8 and 9 return the dur_i, chan_lvl_i and cap_flags_i inputs live, and host writes to them are ignored.
- R7: Long register 10 is capture control. Bit 0 is stored, drives arm_o and reads back. Bits 2, 4, 5 and 6 (clear timebase, flush FIFO, clear FIFO-full, clear counter) each raise their pulse output for exactly the one cycle after the commit, and read back as zero.
- R8: Long register 6 and every undefined long address read as zero, and writes to them alter no register.
- R9: Every read request raises rsp_valid_o for one cycle, one clock later, with rsp_rdata_o. Writes produce no response.
- R10: After reset all outputs, the window slots and the bank are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | SADDR_W | Short byte address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DW | Read data |
| dur_i | input | 2*DW | Live elapsed-time value |
| chan_lvl_i | input | 2*DW | Live input levels |
| cap_flags_i | input | 2*DW | Live capture flags |
| chan_mask_o | output | 2*DW | Channel mask |
| div_count_o | output | 2*DW | Divider count |
| trg_level_o | output | 2*DW | Trigger level/slope bits |
| trg_kind_o | output | 2*DW | Trigger kind bits |
| trg_enable_o | output | 2*DW | Trigger enable mask |
| fill_limit_o | output | 2*DW | Fill limit |
| arm_o | output | 1 | Capture arm level |
| clr_timebase_o | output | 1 | One-cycle clear-timebase pulse |
| flush_fifo_o | output | 1 | One-cycle FIFO flush pulse |
| clr_full_o | output | 1 | One-cycle clear-FIFO-full pulse |
| clr_count_o | output | 1 | One-cycle clear-counter pulse |

## Verification
The bench builds the bridge with its defaults: a 32-bit bus, WIN_BASE 0x10B0 and a 16-bit short address. The 7-bit long space 0 to 127 is small enough to sweep every address. Each address is written with a pattern computed from its index, and all of them are read back after the full write pass. This shows that reserved, live, constant and undefined slots neither store data nor disturb their neighbours. Capture-control values with different mixes of clear bits, a read before any latch, and short addresses outside the window cover the pulse timing, the stale-read case and the decode edges.

// File: rtl/lreg_pkg.sv
package lreg_pkg;
  localparam int NUM_CFG     = 6;
  localparam int LA_RSVD     = 6;
  localparam int LA_DURATION = 7;
  localparam int LA_CHLVL    = 8;
  localparam int LA_FLAGS    = 9;
  localparam int LA_CAPCTL   = 10;
  localparam int LA_TESTID   = 100;
  localparam logic [63:0] TEST_ID_VAL = 64'h1234_5678_8765_4321;

  localparam int CC_ARM      = 0;
  localparam int NUM_PULSE   = 4;

  // pulse index -> capture-control bit
  function automatic int pulse_bit(input int k);
    case (k)
      0:       return 2;
      1:       return 4;
      2:       return 5;
      default: return 6;
    endcase
  endfunction

  typedef enum logic [1:0] {
    WIN_STROBE = 2'd0,
    WIN_ADDR   = 2'd1,
    WIN_LOW    = 2'd2,
    WIN_HIGH   = 2'd3
  } win_sel_e;
endpackage

// File: rtl/lreg_window.sv
module lreg_window
  import lreg_pkg::*;
#(
  parameter int SADDR_W = 16,
  parameter int DW      = 32,
  parameter logic [SADDR_W-1:0] WIN_BASE = 16'h10B0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [SADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_rdata_o,
  input  logic [2*DW-1:0]    bank_rdata_i,
  output logic [DW-1:0]      laddr_o,
  output logic [2*DW-1:0]    lwdata_o,
  output logic               lwr_o
);
  localparam int LW = 2 * DW;

  logic          hit;
  win_sel_e      sel;
  logic          wr, rd;
  logic [DW-1:0] addr_q, low_q, high_q;
  logic [LW-1:0] latch_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  assign hit = (req_addr_i[SADDR_W-1:4] == WIN_BASE[SADDR_W-1:4]) && (req_addr_i[1:0] == 2'b00);
  assign sel = win_sel_e'(req_addr_i[3:2]);
  assign wr  = req_valid_i && req_write_i && hit;
  assign rd  = req_valid_i && !req_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (wr) begin
      case (sel)
        WIN_ADDR: addr_q <= req_wdata_i;
        WIN_LOW:  low_q  <= req_wdata_i;
        WIN_HIGH: high_q <= req_wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              latch_q <= '0;
    else if (rd && hit && sel == WIN_STROBE)  latch_q <= bank_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) begin
        if (!hit) rdata_q <= '0;
        else begin
          case (sel)
            WIN_ADDR: rdata_q <= addr_q;
            WIN_LOW:  rdata_q <= latch_q[DW-1:0];
            WIN_HIGH: rdata_q <= latch_q[LW-1:DW];
            default:  rdata_q <= '0;
          endcase
        end
      end
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
  assign laddr_o     = addr_q;
  assign lwdata_o    = {high_q, low_q};
  assign lwr_o       = wr && (sel == WIN_STROBE);

  // R9
  rsp_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));

  // R4
  test_id_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit && sel == WIN_STROBE && addr_q == DW'(LA_TESTID)) |=> latch_q == TEST_ID_VAL);

  // R3
  strobe_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit && sel == WIN_STROBE) |=> rsp_rdata_o == '0);
endmodule

// File: rtl/lreg_bank.sv
module lreg_bank
  import lreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   addr_i,
  input  logic [2*DW-1:0] wdata_i,
  input  logic            wr_i,
  input  logic [2*DW-1:0] dur_i,
  input  logic [2*DW-1:0] chan_lvl_i,
  input  logic [2*DW-1:0] cap_flags_i,
  output logic [2*DW-1:0] rdata_o,
  output logic [2*DW-1:0] cfg_o [NUM_CFG],
  output logic            arm_o,
  output logic [NUM_PULSE-1:0] pulse_o
);
  localparam int LW = 2 * DW;
  localparam logic [DW-1:0] A_DUR  = DW'(LA_DURATION);
  localparam logic [DW-1:0] A_LVL  = DW'(LA_CHLVL);
  localparam logic [DW-1:0] A_FLG  = DW'(LA_FLAGS);
  localparam logic [DW-1:0] A_CAP  = DW'(LA_CAPCTL);
  localparam logic [DW-1:0] A_TID  = DW'(LA_TESTID);

  logic [LW-1:0] cfg_q [NUM_CFG];
  logic          arm_q;
  logic [NUM_PULSE-1:0] pulse_q;
  logic          cap_wr;

  assign cap_wr = wr_i && (addr_i == A_CAP);

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_q[i] <= '0;
      else if (wr_i && addr_i == DW'(i))        cfg_q[i] <= wdata_i;
    end
    assign cfg_o[i] = cfg_q[i];

    // R5
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(cfg_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= 1'b0;
    else if (cap_wr) arm_q <= wdata_i[CC_ARM];
  end

  for (genvar k = 0; k < NUM_PULSE; k++) begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q[k] <= 1'b0;
      else         pulse_q[k] <= cap_wr && wdata_i[pulse_bit(k)];
    end

    // R7
    pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q[k] |-> $past(wr_i && addr_i == A_CAP));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < DW'(NUM_CFG)) rdata_o = cfg_q[addr_i[$clog2(NUM_CFG)-1:0]];
    else if (addr_i == A_DUR)  rdata_o = dur_i;
    else if (addr_i == A_LVL)  rdata_o = chan_lvl_i;
    else if (addr_i == A_FLG)  rdata_o = cap_flags_i;
    else if (addr_i == A_CAP)  rdata_o = LW'(arm_q);
    else if (addr_i == A_TID)  rdata_o = TEST_ID_VAL;
  end

  assign arm_o   = arm_q;
  assign pulse_o = pulse_q;

  // R7
  arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_wr |=> $stable(arm_q));
endmodule

// File: rtl/lreg_bridge.sv
module lreg_bridge
  import lreg_pkg::*;
#(
  parameter int SADDR_W = 16,
  parameter int DW      = 32,
  parameter logic [SADDR_W-1:0] WIN_BASE = 16'h10B0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [SADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_rdata_o,
  input  logic [2*DW-1:0]    dur_i,
  input  logic [2*DW-1:0]    chan_lvl_i,
  input  logic [2*DW-1:0]    cap_flags_i,
  output logic [2*DW-1:0]    chan_mask_o,
  output logic [2*DW-1:0]    div_count_o,
  output logic [2*DW-1:0]    trg_level_o,
  output logic [2*DW-1:0]    trg_kind_o,
  output logic [2*DW-1:0]    trg_enable_o,
  output logic [2*DW-1:0]    fill_limit_o,
  output logic               arm_o,
  output logic               clr_timebase_o,
  output logic               flush_fifo_o,
  output logic               clr_full_o,
  output logic               clr_count_o
);
  logic [DW-1:0]   laddr;
  logic [2*DW-1:0] lwdata, bank_rdata;
  logic            lwr;
  logic [2*DW-1:0] cfg [NUM_CFG];
  logic [NUM_PULSE-1:0] pulse;

  lreg_window #(.SADDR_W(SADDR_W), .DW(DW), .WIN_BASE(WIN_BASE)) u_win (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o,
    .bank_rdata_i(bank_rdata), .laddr_o(laddr), .lwdata_o(lwdata), .lwr_o(lwr)
  );

  lreg_bank #(.DW(DW)) u_bank (
    .clk_i, .rst_ni, .addr_i(laddr), .wdata_i(lwdata), .wr_i(lwr),
    .dur_i, .chan_lvl_i, .cap_flags_i,
    .rdata_o(bank_rdata), .cfg_o(cfg), .arm_o, .pulse_o(pulse)
  );

  assign chan_mask_o    = cfg[0];
  assign div_count_o    = cfg[1];
  assign trg_level_o    = cfg[2];
  assign trg_kind_o     = cfg[3];
  assign trg_enable_o   = cfg[4];
  assign fill_limit_o   = cfg[5];
  assign clr_timebase_o = pulse[0];
  assign flush_fifo_o   = pulse[1];
  assign clr_full_o     = pulse[2];
  assign clr_count_o    = pulse[3];
endmodule

// File: tb/sim_lreg_bridge.sv
module sim_lreg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rvld;
  logic [31:0] rdata;
  logic [63:0] dur = 64'h0000_0003_0000_0ABC;
  logic [63:0] lvl = 64'h0000_0002_DEAD_BEEF;
  logic [63:0] flg = 64'h0000_0000_0000_002A;
  logic [63:0] cmask, dcnt, tlvl, tkind, tena, flim;
  logic        arm, p_tb, p_fl, p_fu, p_cn;

  int n_chk = 0, n_fail = 0;
  logic [3:0] pulse_seen;

  always #2 clk = ~clk;

  lreg_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_valid_o(rvld), .rsp_rdata_o(rdata),
    .dur_i(dur), .chan_lvl_i(lvl), .cap_flags_i(flg),
    .chan_mask_o(cmask), .div_count_o(dcnt), .trg_level_o(tlvl), .trg_kind_o(tkind),
    .trg_enable_o(tena), .fill_limit_o(flim), .arm_o(arm),
    .clr_timebase_o(p_tb), .flush_fifo_o(p_fl), .clr_full_o(p_fu), .clr_count_o(p_cn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    pulse_seen = {p_cn, p_fu, p_fl, p_tb};
    vld = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    check("R9 rsp_valid", {63'd0, rvld}, 64'd1);
    d = rdata;
    vld = 1'b0;
  endtask

  task automatic lwr(input int la, input logic [63:0] v);
    bwr(16'h10B4, 32'(la));
    bwr(16'h10B8, v[31:0]);
    bwr(16'h10BC, v[63:32]);
    bwr(16'h10B0, 32'h0);
  endtask

  task automatic lrd(input int la, output logic [63:0] v);
    logic [31:0] s, hi, lo;
    bwr(16'h10B4, 32'(la));
    brd(16'h10B0, s);
    check("R3 strobe read zero", {32'd0, s}, 64'd0);
    brd(16'h10BC, hi);
    brd(16'h10B8, lo);
    v = {hi, lo};
  endtask

  function automatic logic [63:0] pat(input int a);
    return {32'hC0DE_0000 + 32'(a), 32'h5A00_0000 ^ (32'(a) * 32'h0101_0101)};
  endfunction

  function automatic logic [63:0] expv(input int a);
    if (a < 6)   return pat(a);
    if (a == 7)  return 64'h0000_0003_0000_0ABC;
    if (a == 8)  return 64'h0000_0002_DEAD_BEEF;
    if (a == 9)  return 64'h0000_0000_0000_002A;
    if (a == 10) return {63'd0, pat(a)[0]};
    if (a == 100) return 64'h1234_5678_8765_4321;
    return 64'd0;
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 outputs", cmask | dcnt | tlvl | tkind | tena | flim, 64'd0);
    check("R10 flags", {58'd0, rvld, arm, p_tb, p_fl, p_fu, p_cn}, 64'd0);
    // R3 stale before any latch
    brd(16'h10BC, d); check("R3 stale high", {32'd0, d}, 64'd0);
    brd(16'h10B8, d); check("R3 stale low", {32'd0, d}, 64'd0);
    // R4 identification word, read twice
    lrd(100, v); check("R4 test id", v, 64'h1234_5678_8765_4321);
    lrd(100, v); check("R4 test id again", v, 64'h1234_5678_8765_4321);
    // R1 address slot readback and out-of-window access
    bwr(16'h10B4, 32'h0001_0007);
    brd(16'h10B4, d); check("R1 addr readback", {32'd0, d}, 64'h0001_0007);
    bwr(16'h10C0, 32'hFFFF_FFFF);
    bwr(16'h10A4, 32'h1234_0000);
    brd(16'h10B4, d); check("R1 foreign write ignored", {32'd0, d}, 64'h0001_0007);
    brd(16'h10C0, d); check("R1 foreign read zero", {32'd0, d}, 64'd0);
    brd(16'h10B6, d); check("R1 misaligned read zero", {32'd0, d}, 64'd0);
    // undefined long address above the 7-bit sweep: R8
    lwr(32'h0001_0007, 64'hFFFF_FFFF_FFFF_FFFF);
    lrd(32'h0001_0007, v); check("R8 wide undefined", v, 64'd0);
    // sweep: R2 R5 R6 R8
    for (int a = 0; a < 128; a++) lwr(a, pat(a));
    for (int a = 0; a < 128; a++) begin
      lrd(a, v);
      check($sformatf("R2/R5/R6/R8 la=%0d", a), v, expv(a));
    end
    // R5 outputs
    check("R5 chan_mask", cmask, pat(0));
    check("R5 div_count", dcnt, pat(1));
    check("R5 trg_level", tlvl, pat(2));
    check("R5 trg_kind", tkind, pat(3));
    check("R5 trg_enable", tena, pat(4));
    check("R5 fill_limit", flim, pat(5));
    // R6 live tracking
    dur = 64'h0000_0000_0000_0055;
    lrd(7, v); check("R6 live duration", v, 64'h55);
    // R7 capture control
    lwr(10, 64'h75);
    check("R7 pulses all", {60'd0, pulse_seen}, 64'hF);
    check("R7 arm set", {63'd0, arm}, 64'd1);
    @(negedge clk);
    check("R7 pulses drop", {60'd0, p_cn, p_fu, p_fl, p_tb}, 64'd0);
    lrd(10, v); check("R7 readback", v, 64'd1);
    lwr(10, 64'h24);
    check("R7 pulses tb+full", {60'd0, pulse_seen}, 64'h5);
    check("R7 arm clear", {63'd0, arm}, 64'd0);
    lwr(10, 64'h50);
    check("R7 pulses flush+cnt", {60'd0, pulse_seen}, 64'hA);
    lwr(3, 64'h7F);
    check("R7 no pulse other reg", {60'd0, pulse_seen}, 64'h0);
    // R9 write gives no response
    @(negedge clk);
    vld = 1'b1; wr = 1'b1; addr = 16'h10B4; wdata = 32'h5;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
    check("R9 no write response", {63'd0, rvld}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule